// File: doc/BRIEF.md
# Radio Coexistence Arbiter

This block settles who owns a shared 2.4 GHz medium when a local WLAN transceiver and a second short-range radio sit side by side. The other radio raises a request line before each transmit or receive slot. The arbiter answers on a single activity line: high blocks that slot, low lets it proceed. It also drives an antenna-select line that follows the outcome, unless firmware takes the antenna over directly.

The request and priority lines come from another clock domain, so they pass through synchronizer chains before any logic uses them. One decision is made per request, at the moment the synchronized request is seen to rise. That decision then holds until the request falls. A mode input picks between the two-line scheme and the three-line scheme. In the two-line scheme the peer's priority line is not consulted. In the three-line scheme that line can win the medium from ordinary WLAN traffic. A global enable switches arbitration off, and while it is off every request is granted. All control pins are plain levels; the block carries no data stream, so it has no valid/ready handshake.

Top module: `coex_arbiter`

## Requirements
- R1: With the default of two synchronizer stages, a request that goes high between clock edges moves `peer_block` no earlier than the third rising edge after the change, and exactly at that edge when the decision is to block.
- R2: When `three_wire` is 0, a request is blocked (`peer_block`=1) if `wl_busy` is 1 at the decision edge, and granted otherwise, whatever the level of `peer_prio_async`.
- R3: When `three_wire` is 1 and the synchronized priority is 0 (normal slot), a request is blocked exactly when `wl_busy` is 1.
- R4: When `three_wire` is 1 and the synchronized priority is 1 (high-priority slot), a request is blocked only when both `wl_busy` and `wl_hiprio` are 1.
- R5: Once made, the decision holds for as long as the synchronized request stays high. Later changes on `wl_busy`, `wl_hiprio`, `three_wire` or the priority line leave `peer_block` unchanged.
- R6: `peer_block` returns to 0 on the third rising edge after the request input falls, and stays 0 while no request is held.
- R7: While `coex_en` is 0, `peer_block` is 0 from the next rising edge onward, so every request is granted. Raising `coex_en` in the middle of a request does not re-evaluate that request.
- R8: When `ant_ovr_en` is 0, `ant_sel` is 1 (antenna to the peer radio) exactly while a held request has been granted with `coex_en` high, and 0 otherwise. When `ant_ovr_en` is 1, `ant_sel` equals `ant_ovr_sel` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| coex_en | input | 1 | 1 enables arbitration; 0 grants every request |
| three_wire | input | 1 | 0 selects the two-line scheme, 1 the three-line scheme |
| peer_req_async | input | 1 | Peer radio slot request, asynchronous |
| peer_prio_async | input | 1 | Peer slot priority (1 = high), asynchronous |
| wl_busy | input | 1 | Local WLAN is transmitting or receiving |
| wl_hiprio | input | 1 | Local WLAN traffic is marked high priority |
| ant_ovr_en | input | 1 | Firmware takes direct control of the antenna |
| ant_ovr_sel | input | 1 | Antenna choice used while the override is on |
| peer_block | output | 1 | 1 = the peer's current slot is denied |
| ant_sel | output | 1 | 1 = antenna routed to the peer radio |

## Verification
The hardest situation to reach is a decision that must stay frozen while every input feeding it moves. Reaching it takes a request held high across several cycles while the WLAN state, the priority line and even the mode select are re-randomized. The bench holds each random request for one to four cycles after the decision and scrambles those inputs at each cycle. A directed case drops and restores the enable in the middle of a held request, to show the request is not re-evaluated.

// File: rtl/coex_pkg.sv
package coex_pkg;

  typedef enum logic {
    WIRE2 = 1'b0,
    WIRE3 = 1'b1
  } wire_mode_e;

  // Block decision for one peer request (1 = deny the slot).
  function automatic logic block_for(wire_mode_e mode, logic prio,
                                     logic busy, logic hiprio);
    logic res;
    if (mode == WIRE2) begin
      res = busy;
    end else if (prio) begin
      res = busy & hiprio;
    end else begin
      res = busy;
    end
    return res;
  endfunction

endpackage

// File: rtl/coex_sync.sv
module coex_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/coex_edge.sv
module coex_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise,
  output logic fall
);

  logic lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;
  assign fall = ~lvl & lvl_q;

endmodule

// File: rtl/coex_decide.sv
module coex_decide
  import coex_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  wire_mode_e mode,
  input  logic       req_lvl,
  input  logic       rise,
  input  logic       fall,
  input  logic       prio,
  input  logic       busy,
  input  logic       hiprio,
  output logic       block,
  output logic       owns
);

  logic verdict;

  assign verdict = block_for(mode, prio, busy, hiprio);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      block <= 1'b0;
      owns  <= 1'b0;
    end else if (!en) begin
      block <= 1'b0;
      owns  <= 1'b0;
    end else if (rise) begin
      block <= verdict;
      owns  <= ~verdict;
    end else if (fall) begin
      block <= 1'b0;
      owns  <= 1'b0;
    end
  end

  // R2: two-line scheme follows WLAN activity only
  assert_two_wire_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && en && mode == WIRE2) |=> (block == $past(busy)));

  // R3: three-line scheme, normal priority
  assert_normal_prio_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && en && mode == WIRE3 && !prio) |=> (block == $past(busy)));

  // R4: three-line scheme, high priority
  assert_high_prio_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && en && mode == WIRE3 && prio) |=> (block == ($past(busy) && $past(hiprio))));

  // R5: decision frozen while the request is held
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(req_lvl) && !$past(rise) && $past(en)) |-> $stable(block));

  // R6: release on request fall
  assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !block);

  // R7: disabled arbitration blocks nothing
  assert_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!block && !owns));

  // R8: the peer never owns the antenna and is blocked at once
  assert_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({block, owns}));

endmodule

// File: rtl/coex_antsel.sv
module coex_antsel (
  input  logic ovr_en,
  input  logic ovr_sel,
  input  logic owns,
  output logic ant
);

  always_comb begin
    if (ovr_en) ant = ovr_sel;
    else        ant = owns;
  end

endmodule

// File: rtl/coex_arbiter.sv
module coex_arbiter
  import coex_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic coex_en,
  input  logic three_wire,
  input  logic peer_req_async,
  input  logic peer_prio_async,
  input  logic wl_busy,
  input  logic wl_hiprio,
  input  logic ant_ovr_en,
  input  logic ant_ovr_sel,
  output logic peer_block,
  output logic ant_sel
);

  localparam int NSYNC = 2;

  logic [NSYNC-1:0] raw_in;
  logic [NSYNC-1:0] synced;
  logic             req_s;
  logic             prio_s;
  logic             req_rise;
  logic             req_fall;
  logic             peer_owns;
  wire_mode_e       mode;

  assign raw_in = {peer_prio_async, peer_req_async};
  assign req_s  = synced[0];
  assign prio_s = synced[1];
  assign mode   = wire_mode_e'(three_wire);

  coex_sync #(.STAGES(SYNC_STAGES), .WIDTH(NSYNC)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw_in),
    .q     (synced)
  );

  coex_edge u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl   (req_s),
    .rise  (req_rise),
    .fall  (req_fall)
  );

  coex_decide u_decide (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (coex_en),
    .mode    (mode),
    .req_lvl (req_s),
    .rise    (req_rise),
    .fall    (req_fall),
    .prio    (prio_s),
    .busy    (wl_busy),
    .hiprio  (wl_hiprio),
    .block   (peer_block),
    .owns    (peer_owns)
  );

  coex_antsel u_ant (
    .ovr_en  (ant_ovr_en),
    .ovr_sel (ant_ovr_sel),
    .owns    (peer_owns),
    .ant     (ant_sel)
  );

  // R6: nothing is blocked while the synchronized request is low and settled
  assert_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_s && !req_fall) |-> !peer_block);

endmodule

// File: tb/coex_arbiter_test.sv
`timescale 1ns/1ps
module coex_arbiter_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic coex_en = 1'b0, three_wire = 1'b0;
  logic req = 1'b0, prio = 1'b0, busy = 1'b0, hip = 1'b0;
  logic ovr_en = 1'b0, ovr_sel = 1'b0;
  logic peer_block, ant_sel;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  coex_arbiter uut (
    .clk(clk), .rst_n(rst_n), .coex_en(coex_en), .three_wire(three_wire),
    .peer_req_async(req), .peer_prio_async(prio), .wl_busy(busy),
    .wl_hiprio(hip), .ant_ovr_en(ovr_en), .ant_ovr_sel(ovr_sel),
    .peer_block(peer_block), .ant_sel(ant_sel)
  );

  function automatic logic exp_block(logic en, logic m3, logic p, logic b, logic h);
    if (!en) return 1'b0;
    if (!m3) return b;
    if (p) return b & h;
    return b;
  endfunction

  function automatic string rule_of(logic en, logic m3, logic p);
    if (!en) return "R7";
    if (!m3) return "R2";
    return p ? "R4" : "R3";
  endfunction

  task automatic chk(logic got, logic exp, string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b at cycle %0d", tag, got, exp, cyc);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  task automatic one_request(logic en, logic m3, logic p, logic b, logic h, int hold);
    logic e;
    @(negedge clk);
    coex_en = en; three_wire = m3; prio = p; busy = b; hip = h; req = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(peer_block, 1'b0, "R1 early");
    @(negedge clk);
    e = exp_block(en, m3, p, b, h);
    chk(peer_block, e, rule_of(en, m3, p));
    chk(ant_sel, en & ~e, "R8 grant");
    for (int i = 0; i < hold; i++) begin
      busy = 1'($urandom); hip = 1'($urandom);
      prio = 1'($urandom); three_wire = 1'($urandom);
      @(negedge clk);
      chk(peer_block, e, "R5 hold");
    end
    req = 1'b0;
    @(negedge clk); @(negedge clk);
    chk(peer_block, e, "R6 late");
    @(negedge clk);
    chk(peer_block, 1'b0, "R6 release");
    chk(ant_sel, 1'b0, "R8 idle");
  endtask

  initial begin
    void'($urandom(32'd20250611));
    repeat (3) @(negedge clk);
    chk(peer_block, 1'b0, "R6 reset");
    chk(ant_sel, 1'b0, "R8 reset");
    rst_n = 1'b1;

    // directed corners
    one_request(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 2); // R2 prio ignored
    one_request(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1);
    one_request(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 2); // R3
    one_request(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 2); // R4 granted
    one_request(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 2); // R4 blocked
    one_request(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 2); // R7

    // R7: disable in the middle of a blocked request, then re-enable
    @(negedge clk);
    coex_en = 1'b1; three_wire = 1'b0; busy = 1'b1; req = 1'b1;
    repeat (3) @(negedge clk);
    chk(peer_block, 1'b1, "R2 before disable");
    coex_en = 1'b0;
    @(negedge clk);
    chk(peer_block, 1'b0, "R7 mid-request");
    coex_en = 1'b1;
    repeat (2) @(negedge clk);
    chk(peer_block, 1'b0, "R7 no re-evaluation");
    req = 1'b0;
    repeat (4) @(negedge clk);

    // R8: override of the antenna
    ovr_en = 1'b1; ovr_sel = 1'b1; #1;
    chk(ant_sel, 1'b1, "R8 override high");
    ovr_sel = 1'b0; #1;
    chk(ant_sel, 1'b0, "R8 override low");
    busy = 1'b0; req = 1'b1;
    repeat (4) @(negedge clk);
    chk(ant_sel, 1'b0, "R8 override over grant");
    ovr_en = 1'b0; #1;
    chk(ant_sel, 1'b1, "R8 grant after override");
    req = 1'b0;
    repeat (4) @(negedge clk);

    // random traffic
    for (int n = 0; n < 120; n++) begin
      one_request(($urandom % 8) != 0, 1'($urandom), 1'($urandom),
                  1'($urandom), 1'($urandom), 1 + ($urandom % 4));
    end
    finish_run();
  end

endmodule